// File: doc/BRIEF.md
# Single-Wire Pulse-Width Frame Master

This block runs one complete transaction on a single-wire battery sensor bus whose bits are coded by how long the line is held low. A host presents a frame request: a direction bit, a 3-bit slave address, a 3-bit register index, a write flag and a write byte. It then pulses `start`. The controller walks the frame slot by slot. First come the sync pulses. Next are the eight header bits and the header parity. On a write the controller then sends the data byte and the data parity. On a read it lets the slave drive those slots instead. The final slot is always the slave's acknowledge.

The controller does not shape pulses on the wire itself. For each bit slot it issues one request to a separate bit transceiver over a valid/ready handshake. Each request names the slot kind: sync, send zero, send one, or listen. The transceiver answers each accepted request with exactly one response, which carries the sampled level on listen slots. The master opens every slot, including the slots in which the slave drives the data. When the acknowledge response arrives, the controller posts the read byte, a parity-error flag and the acknowledge status, and pulses `done`.

The register field on the wire is formed as {write flag, register index}, so its top bit marks a write. The header parity covers the direction bit, the slave address and that register field.

Top module: `swbus_frame_master`

## Requirements
- R1: After reset, `busy`, `done`, `bit_req_valid`, `rd_data`, `parity_error` and `ack_ok` are all 0.
- R2: A `start` seen while idle captures the request fields and raises `busy` on the next cycle. A `start` seen while `busy` is high is ignored: the slots of the current frame are unchanged, and no second frame follows.
- R3: Each frame opens with `SYNC_PULSES` slots of kind sync (code 0). The default is 3.
- R4: Next come 8 header slots, most significant bit first, in this order: direction, slave address bits 2..0, write flag, register index bits 2..0. A 0 is sent as kind code 1 and a 1 as kind code 2.
- R5: The slot after the header sends P1. P1 is a 1 when the 8 header bits hold an odd number of ones, and a 0 otherwise.
- R6: On a write frame the controller sends 8 data slots from `wdata`, MSB first. It then sends P2, the odd-count parity of `wdata`, followed by one listen slot (code 3) for the acknowledge.
- R7: On a read frame the 10 slots after P1 are all listen slots: 8 data bits MSB first, then P2, then the acknowledge. `rd_data` shows the collected byte.
- R8: On a read, `parity_error` is 1 exactly when the received P2 differs from the odd-count parity of the received byte. On a write, `parity_error` and `rd_data` are 0.
- R9: `ack_ok` is 1 exactly when the acknowledge bit returned by the slave is 0.
- R10: `done` is a one-cycle pulse in the cycle after the acknowledge response. `busy` is low in that same cycle. The results hold until the next frame's `done`.
- R11: `bit_req_valid` stays high with a stable `bit_req_kind` until `bit_req_ready` is seen. Each slot issues exactly one request. A `bit_rsp_valid` that arrives while no accepted request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (acted on only while idle) |
| dir | input | 1 | Direction bit placed first in the header |
| slave_addr | input | 3 | Slave address |
| reg_idx | input | 3 | Register index, lower bits of the register field |
| write | input | 1 | Write flag, top bit of the register field |
| wdata | input | 8 | Byte sent on write frames |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 8 | Byte received on a read frame |
| parity_error | output | 1 | Received data parity mismatch |
| ack_ok | output | 1 | Slave acknowledged (ACK bit was 0) |
| bit_req_valid | output | 1 | Slot request to the bit transceiver |
| bit_req_ready | input | 1 | Transceiver accepts the request |
| bit_req_kind | output | 2 | 0 sync, 1 send zero, 2 send one, 3 listen |
| bit_rsp_valid | input | 1 | Transceiver finished the slot |
| bit_rsp_bit | input | 1 | Level sampled on a listen slot |

## Verification
A wrong slot counter or phase shows up at once on `bit_req_kind`: within the slot it corrupts, a sync, header or parity request carries the wrong code. The bench therefore logs every request kind and compares the full 22-slot sequence of each frame. Errors in capture or parity only surface at `done`, about 22 handshakes after `start`. They are checked through `rd_data`, `parity_error` and `ack_ok` with known slave replies, including a deliberately wrong P2. A stuck handshake flag shows as `busy` held high with no further requests. Stray responses and stalls are injected to catch a controller that advances without an accepted request.

// File: rtl/swbus_pkg.sv
package swbus_pkg;

    localparam int SA_W   = 3;
    localparam int RI_W   = 3;
    localparam int DATA_W = 8;
    localparam int HDR_W  = 1 + SA_W + 1 + RI_W;

    // Slot kinds handed to the bit transceiver
    typedef enum logic [1:0] {
        K_SYNC   = 2'd0,
        K_ZERO   = 2'd1,
        K_ONE    = 2'd2,
        K_LISTEN = 2'd3
    } slot_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SYNC,
        PH_HDR,
        PH_P1,
        PH_DATA,
        PH_P2,
        PH_ACK
    } phase_e;

    typedef struct packed {
        logic              dir;
        logic [SA_W-1:0]   sa;
        logic              wr;
        logic [RI_W-1:0]   ri;
        logic [DATA_W-1:0] wdata;
    } frame_req_t;

    function automatic logic [HDR_W-1:0] hdr_word(input frame_req_t r);
        return {r.dir, r.sa, r.wr, r.ri};
    endfunction

    function automatic slot_kind_e bit_kind(input logic b);
        return b ? K_ONE : K_ZERO;
    endfunction

endpackage

// File: rtl/swbus_slot_seq.sv
module swbus_slot_seq
    import swbus_pkg::*;
#(
    parameter int SYNC_PULSES = 3,
    parameter int IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             wr,
    input  logic             req_ready,
    input  logic             rsp_valid,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             req_valid,
    output logic             slot_fire,
    output logic             frame_end
);

    phase_e           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic             wait_q;   // request accepted, response outstanding

    assign phase     = phase_q;
    assign idx       = idx_q;
    assign req_valid = (phase_q != PH_IDLE) && !wait_q;
    assign slot_fire = wait_q && rsp_valid;
    assign frame_end = slot_fire && (phase_q == PH_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            wait_q  <= 1'b0;
        end else if (phase_q == PH_IDLE) begin
            if (start) begin
                phase_q <= PH_SYNC;
                idx_q   <= '0;
                wait_q  <= 1'b0;
            end
        end else if (!wait_q) begin
            if (req_ready) wait_q <= 1'b1;
        end else if (rsp_valid) begin
            wait_q <= 1'b0;
            unique case (phase_q)
                PH_SYNC: begin
                    if (idx_q == IDX_W'(SYNC_PULSES - 1)) begin
                        phase_q <= PH_HDR;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_HDR: begin
                    if (idx_q == IDX_W'(HDR_W - 1)) begin
                        phase_q <= PH_P1;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_P1: begin
                    phase_q <= PH_DATA;
                    idx_q   <= '0;
                end
                PH_DATA: begin
                    if (idx_q == IDX_W'(DATA_W - 1)) begin
                        phase_q <= PH_P2;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_P2:   phase_q <= PH_ACK;
                PH_ACK:  phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R11: the slot position never moves while a request waits for acceptance
    p_stray_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> ($stable(phase_q) && $stable(idx_q)));

    // R3: the header starts only after the last sync slot completes
    p_sync_len_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HDR && $past(phase_q) == PH_SYNC)
            |-> ($past(idx_q) == IDX_W'(SYNC_PULSES - 1) && $past(wr) == wr));

endmodule

// File: rtl/swbus_tx_map.sv
module swbus_tx_map
    import swbus_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  phase_e           phase,
    input  logic [IDX_W-1:0] idx,
    input  frame_req_t       req,
    output slot_kind_e       kind
);

    logic [HDR_W-1:0]  hdr;
    logic [HDR_W-1:0]  hdr_sh;
    logic [DATA_W-1:0] dat_sh;

    assign hdr    = hdr_word(req);
    assign hdr_sh = hdr << idx;        // MSB-first selection
    assign dat_sh = req.wdata << idx;

    always_comb begin
        unique case (phase)
            PH_SYNC: kind = K_SYNC;
            PH_HDR:  kind = bit_kind(hdr_sh[HDR_W-1]);
            PH_P1:   kind = bit_kind(^hdr);
            PH_DATA: kind = req.wr ? bit_kind(dat_sh[DATA_W-1]) : K_LISTEN;
            PH_P2:   kind = req.wr ? bit_kind(^req.wdata) : K_LISTEN;
            PH_ACK:  kind = K_LISTEN;
            default: kind = K_SYNC;
        endcase
    end

endmodule

// File: rtl/swbus_rx_capture.sv
module swbus_rx_capture
    import swbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_fire,
    input  phase_e            phase,
    input  logic              wr,
    input  logic              rsp_bit,
    output logic [DATA_W-1:0] rd_data,
    output logic              parity_error,
    output logic              ack_ok
);

    logic [DATA_W-1:0] sh_q;
    logic              p2_q;
    logic [DATA_W-1:0] rd_q;
    logic              perr_q;
    logic              ack_q;

    assign rd_data      = rd_q;
    assign parity_error = perr_q;
    assign ack_ok       = ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            p2_q   <= 1'b0;
            rd_q   <= '0;
            perr_q <= 1'b0;
            ack_q  <= 1'b0;
        end else if (slot_fire) begin
            unique case (phase)
                PH_DATA: if (!wr) sh_q <= {sh_q[DATA_W-2:0], rsp_bit};
                PH_P2:   if (!wr) p2_q <= rsp_bit;
                PH_ACK: begin
                    rd_q   <= wr ? '0 : sh_q;
                    perr_q <= !wr && ((^sh_q) != p2_q);
                    ack_q  <= !rsp_bit;
                end
                default: ;
            endcase
        end
    end

    // R8: a write frame never posts a parity error or read data
    p_write_clean_r8: assert property (@(posedge clk) disable iff (rst)
        (slot_fire && phase == PH_ACK && wr) |=> (!perr_q && rd_q == '0));

endmodule

// File: rtl/swbus_frame_master.sv
module swbus_frame_master
    import swbus_pkg::*;
#(
    parameter int SYNC_PULSES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir,
    input  logic [SA_W-1:0]   slave_addr,
    input  logic [RI_W-1:0]   reg_idx,
    input  logic              write,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              parity_error,
    output logic              ack_ok,
    output logic              bit_req_valid,
    input  logic              bit_req_ready,
    output logic [1:0]        bit_req_kind,
    input  logic              bit_rsp_valid,
    input  logic              bit_rsp_bit
);

    localparam int MAXN  = (SYNC_PULSES > HDR_W) ? SYNC_PULSES : HDR_W;
    localparam int IDX_W = $clog2(MAXN);

    frame_req_t       req_q;
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             slot_fire;
    logic             frame_end;
    logic             done_q;
    slot_kind_e       kind;

    assign busy         = (phase != PH_IDLE);
    assign done         = done_q;
    assign bit_req_kind = kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= frame_end;
            if (!busy && start)
                req_q <= '{dir: dir, sa: slave_addr, wr: write, ri: reg_idx, wdata: wdata};
        end
    end

    swbus_slot_seq #(.SYNC_PULSES(SYNC_PULSES), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wr        (req_q.wr),
        .req_ready (bit_req_ready),
        .rsp_valid (bit_rsp_valid),
        .phase     (phase),
        .idx       (idx),
        .req_valid (bit_req_valid),
        .slot_fire (slot_fire),
        .frame_end (frame_end)
    );

    swbus_tx_map #(.IDX_W(IDX_W)) u_tx (
        .phase (phase),
        .idx   (idx),
        .req   (req_q),
        .kind  (kind)
    );

    swbus_rx_capture u_rx (
        .clk          (clk),
        .rst          (rst),
        .slot_fire    (slot_fire),
        .phase        (phase),
        .wr           (req_q.wr),
        .rsp_bit      (bit_rsp_bit),
        .rd_data      (rd_data),
        .parity_error (parity_error),
        .ack_ok       (ack_ok)
    );

    // R11: a pending request holds its kind until accepted
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (bit_req_valid && !bit_req_ready) |=> (bit_req_valid && $stable(bit_req_kind)));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: busy is already low while done is high
    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2: a start during a frame leaves the captured request untouched
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(req_q));

endmodule

// File: tb/swbus_frame_master_tb.sv
`timescale 1ns/1ps
module swbus_frame_master_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       start, dir, write;
    logic [2:0] slave_addr, reg_idx;
    logic [7:0] wdata;
    logic       busy, done, parity_error, ack_ok;
    logic [7:0] rd_data;
    logic       bit_req_valid, bit_req_ready, bit_rsp_valid, bit_rsp_bit;
    logic [1:0] bit_req_kind;

    always #2.5 clk = ~clk;

    swbus_frame_master u_dut (
        .clk(clk), .rst(rst), .start(start), .dir(dir), .slave_addr(slave_addr),
        .reg_idx(reg_idx), .write(write), .wdata(wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .parity_error(parity_error), .ack_ok(ack_ok),
        .bit_req_valid(bit_req_valid), .bit_req_ready(bit_req_ready),
        .bit_req_kind(bit_req_kind), .bit_rsp_valid(bit_rsp_valid),
        .bit_rsp_bit(bit_rsp_bit)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Transceiver model state
    logic [1:0] klog [0:63];
    int         nlog;
    logic       s_bits [0:15];
    int         sidx;
    int         ready_dly = 0;
    int         rsp_dly = 0;
    bit         stray = 0;
    logic [1:0] k;

    initial begin
        bit_req_ready = 1'b0;
        bit_rsp_valid = 1'b0;
        bit_rsp_bit   = 1'b0;
        forever begin
            @(negedge clk);
            if (bit_req_valid && !rst) begin
                k = bit_req_kind;
                for (int d = 0; d < ready_dly; d++) begin
                    if (stray && d == 0) begin
                        bit_rsp_valid = 1'b1;
                        bit_rsp_bit   = 1'b1;
                    end
                    @(negedge clk);
                    bit_rsp_valid = 1'b0;
                    chk(bit_req_valid && bit_req_kind == k, "R11 request held", {bit_req_valid, bit_req_kind}, {1'b1, k});
                end
                if (nlog < 64) klog[nlog] = k;
                nlog++;
                bit_req_ready = 1'b1;
                @(negedge clk);
                bit_req_ready = 1'b0;
                for (int d = 0; d < rsp_dly; d++) @(negedge clk);
                if (k == 2'd3) begin
                    bit_rsp_bit = s_bits[sidx];
                    sidx++;
                end else begin
                    bit_rsp_bit = 1'b0;
                end
                bit_rsp_valid = 1'b1;
                @(negedge clk);
                bit_rsp_valid = 1'b0;
            end
        end
    end

    // Vector: {dir, sa[2:0], wr, ri[2:0], wdata[7:0], slave_data[7:0], p2_flip, ack_bit}
    localparam int NV = 7;
    localparam logic [25:0] VEC [0:NV-1] = '{
        {1'b0, 3'd5, 1'b1, 3'd2, 8'hA5, 8'h00, 1'b0, 1'b0},
        {1'b1, 3'd7, 1'b1, 3'd7, 8'hFF, 8'h00, 1'b0, 1'b1},
        {1'b0, 3'd3, 1'b0, 3'd4, 8'h00, 8'h3C, 1'b0, 1'b0},
        {1'b0, 3'd1, 1'b0, 3'd0, 8'h00, 8'h81, 1'b1, 1'b0},
        {1'b1, 3'd0, 1'b0, 3'd1, 8'h00, 8'h00, 1'b0, 1'b1},
        {1'b0, 3'd0, 1'b1, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0},
        {1'b0, 3'd6, 1'b0, 3'd5, 8'h00, 8'hFE, 1'b1, 1'b0}
    };

    function automatic logic [1:0] kof(input logic b);
        return b ? 2'd2 : 2'd1;
    endfunction

    task automatic launch(input logic [25:0] v);
        logic [7:0] sd;
        sd = v[9:2];
        nlog = 0;
        sidx = 0;
        if (v[21]) begin
            s_bits[0] = v[0];
        end else begin
            for (int i = 0; i < 8; i++) s_bits[i] = sd[7-i];
            s_bits[8] = (^sd) ^ v[1];
            s_bits[9] = v[0];
        end
        dir = v[25]; slave_addr = v[24:22]; write = v[21]; reg_idx = v[20:18]; wdata = v[17:10];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
    endtask

    task automatic finish_frame(input logic [25:0] v);
        logic [1:0] ex [0:21];
        logic [7:0] hdr, wd, sd;
        bit         ok3, ok4, ok5, ok67;
        while (!done) @(negedge clk);
        hdr = v[25:18]; wd = v[17:10]; sd = v[9:2];
        for (int i = 0; i < 3; i++) ex[i] = 2'd0;
        for (int i = 0; i < 8; i++) ex[3+i] = kof(hdr[7-i]);
        ex[11] = kof(^hdr);
        for (int i = 0; i < 8; i++) ex[12+i] = v[21] ? kof(wd[7-i]) : 2'd3;
        ex[20] = v[21] ? kof(^wd) : 2'd3;
        ex[21] = 2'd3;
        chk(nlog == 22, "R11 one request per slot", nlog, 22);
        ok3 = 1; ok4 = 1; ok5 = 1; ok67 = 1;
        for (int i = 0; i < 22; i++) begin
            if (klog[i] != ex[i]) begin
                if (i < 3) ok3 = 0; else if (i < 11) ok4 = 0; else if (i == 11) ok5 = 0; else ok67 = 0;
            end
        end
        chk(ok3, "R3 sync slots", {klog[0], klog[1], klog[2]}, {ex[0], ex[1], ex[2]});
        chk(ok4, "R4 header slots", hdr, v[25:18]);
        chk(ok5, "R5 header parity", klog[11], ex[11]);
        chk(ok67, v[21] ? "R6 write tail" : "R7 read tail", klog[20], ex[20]);
        chk(busy == 1'b0, "R10 busy low at done", busy, 0);
        chk(rd_data == (v[21] ? 8'h00 : sd), v[21] ? "R8 rd_data on write" : "R7 rd_data", rd_data, v[21] ? 8'h00 : sd);
        chk(parity_error == (!v[21] && v[1]), "R8 parity_error", parity_error, !v[21] && v[1]);
        chk(ack_ok == !v[0], "R9 ack_ok", ack_ok, !v[0]);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single pulse", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; dir = 0; write = 0; slave_addr = 0; reg_idx = 0; wdata = 0;
        nlog = 0; sidx = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk({busy, done, bit_req_valid, rd_data, parity_error, ack_ok} == '0, "R1 reset state",
            {busy, done, bit_req_valid, rd_data, parity_error, ack_ok}, 0);

        // Table walk
        for (int n = 0; n < NV; n++) begin
            launch(VEC[n]);
            finish_frame(VEC[n]);
            @(negedge clk);
        end

        // R10: results hold after done
        repeat (10) @(negedge clk);
        chk(rd_data == 8'hFE && parity_error == 1'b1, "R10 results held", {rd_data, parity_error}, {8'hFE, 1'b1});

        // R2: start during a frame is ignored
        fork
            begin
                launch(VEC[2]);
                finish_frame(VEC[2]);
            end
            begin
                repeat (8) @(negedge clk);
                dir = 1; slave_addr = 3'd7; write = 1; reg_idx = 3'd7; wdata = 8'hFF;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (5) @(negedge clk);
        chk(!busy && !bit_req_valid, "R2 no second frame", {busy, bit_req_valid}, 0);

        // R11: stalls and stray responses
        ready_dly = 2; rsp_dly = 1; stray = 1;
        launch(VEC[3]);
        finish_frame(VEC[3]);
        launch(VEC[0]);
        finish_frame(VEC[0]);
        ready_dly = 0; rsp_dly = 0; stray = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule